// File: doc/BRIEF.md
# Nibble Rate Buffer with Controller and Stream Ports

This block stores 36 four-bit nibbles. It is built once for the transmit direction and once for the receive direction. A parameter picks which side it serves. The storage has three ways in:

- **Controller port.** It treats the buffer as random-access memory. The controller first loads an address pointer, then reads or writes nibbles through a data strobe. An optional auto-increment steps the pointer after each data access.
- **Voice port.** It presents one stream location. An internal pointer walks the buffer one entry per strobe, and its value is visible on an output.
- **Modem port.** It walks the buffer circularly at bit-clock rate, one entry per tick.

Direction of data on the stream ports depends on the side:

| Side | Voice port | Modem port |
|------|------------|------------|
| Transmit | writes | reads |
| Receive | reads | writes |

The depth is not a power of two, so every pointer wraps from 35 back to 0. All reads are registered: read data appears one cycle after its strobe and holds until the next read on the same port. When the controller and the stream writer hit the same entry in the same cycle, the controller's data is kept.

Top module: `nibble_rate_buf`

## Requirements
- R1: Each of the 36 entries (addresses 0 to 35) holds a 4-bit value, and a controller write followed by a controller read of the same address returns that value.
- R2: A controller read (`ctl_rd`) at the current controller pointer presents the entry on `ctl_rdata` after the next rising edge, and `ctl_rdata` holds until the next controller read.
- R3: With the auto-increment bit captured as 1 at the last address load, the controller pointer advances by one after each cycle with `ctl_wr` or `ctl_rd`; with it captured as 0, the pointer stays put.
- R4: Every pointer at 35 that advances goes to 0. An address load of 36 to 63 sets the controller pointer to the loaded value minus 36.
- R5: Each `vp_stb` advances the voice pointer by one. On the transmit side it writes `vp_wdata` at the voice pointer. On the receive side it presents the entry at the voice pointer on `vp_rdata` after the edge.
- R6: `vp_ptr` always shows the voice pointer.
- R7: Each `mdm_tick` advances the modem pointer by one. On the transmit side it presents the entry at the modem pointer on `mdm_rdata` after the edge. On the receive side it writes `mdm_wdata` there.
- R8: A controller write and a stream write to the same entry in the same cycle leave the controller's data in the entry, and both pointers still advance as normal.
- R9: Reset sets all pointers, all entries and all read outputs to 0.
- R10: A read in the same cycle as a write to the same entry returns the content from before the write.
- R11: An address load in the same cycle as a controller data access uses the old address for the access, and the loaded value replaces any increment.
- R12: Ports that do not apply to the configured side have no effect. The transmit side ignores `mdm_wdata` and holds `vp_rdata` at 0. The receive side ignores `vp_wdata` and holds `mdm_rdata` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_addr_we | input | 1 | Load controller pointer and auto-increment bit |
| ctl_addr_wdata | input | AW (6) | Address to load |
| ctl_autoinc_wdata | input | 1 | Auto-increment bit to load |
| ctl_wr | input | 1 | Controller data write strobe |
| ctl_wdata | input | DW (4) | Controller write nibble |
| ctl_rd | input | 1 | Controller data read strobe |
| ctl_rdata | output | DW (4) | Controller read nibble |
| vp_stb | input | 1 | Voice port access strobe |
| vp_wdata | input | DW (4) | Voice write nibble (transmit side) |
| vp_rdata | output | DW (4) | Voice read nibble (receive side) |
| vp_ptr | output | AW (6) | Current voice pointer |
| mdm_tick | input | 1 | Modem bit-rate access tick |
| mdm_wdata | input | DW (4) | Modem write nibble (receive side) |
| mdm_rdata | output | DW (4) | Modem read nibble (transmit side) |

## Verification
The hardest case to reach is a same-entry collision: a controller write must land on an entry in exactly the cycle when the free-running stream pointer points at it. The controller pointer is loaded, but the stream pointers can only advance.

The stimulus therefore resets the block so that all three pointers start at zero. It then fires the controller write, the voice strobe and the modem tick in one cycle. Next it aligns a controller read with a stream write on entry 1, which shows the read-before-write order.

A behavioural model with plain integer pointers and arrays checks every cycle. Both side variants are driven with the same stimulus, including long random stretches that cross the wrap point many times.

// File: rtl/nrb_pkg.sv
package nrb_pkg;

    // Which direction a buffer instance serves.
    typedef enum logic {
        SIDE_TX = 1'b0,
        SIDE_RX = 1'b1
    } side_e;

endpackage

// File: rtl/nrb_ptr.sv
// Modulo-DEPTH pointer with a load that folds values above the depth.
module nrb_ptr #(
    parameter int DEPTH = 36,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    output logic [AW-1:0] ptr
);
    localparam logic [AW:0]   DEPTH_W = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);

    logic [AW:0]   ld_wide;
    logic [AW-1:0] ld_fold;
    logic [AW-1:0] nxt;

    always_comb begin
        ld_wide = {1'b0, load_val};
        if (ld_wide >= DEPTH_W) begin
            ld_fold = AW'(ld_wide - DEPTH_W);
        end else begin
            ld_fold = load_val;
        end
        nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    // Load has priority over advance (R11).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= ld_fold;
        end else if (adv) begin
            ptr <= nxt;
        end
    end

    p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, ptr} < DEPTH_W);

    p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && ptr == LAST) |=> (ptr == '0));

    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> $stable(ptr));

endmodule

// File: rtl/nrb_mem.sv
// Nibble storage: two write ports (port A wins on collision) and two
// registered read ports that return pre-write content.
module nrb_mem #(
    parameter int DEPTH = 36,
    parameter int DW    = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wa_en,
    input  logic [AW-1:0] wa_addr,
    input  logic [DW-1:0] wa_data,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [DW-1:0] wb_data,
    input  logic          r0_en,
    input  logic [AW-1:0] r0_addr,
    output logic [DW-1:0] r0_data,
    input  logic          r1_en,
    input  logic [AW-1:0] r1_addr,
    output logic [DW-1:0] r1_data
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                store[i] <= '0;
            end
        end else begin
            if (wb_en) begin
                store[wb_addr] <= wb_data;
            end
            // Port A is written last so it wins on the same entry (R8).
            if (wa_en) begin
                store[wa_addr] <= wa_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r0_data <= '0;
            r1_data <= '0;
        end else begin
            if (r0_en) begin
                r0_data <= store[r0_addr];
            end
            if (r1_en) begin
                r1_data <= store[r1_addr];
            end
        end
    end

    p_ctl_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && wb_en && wa_addr == wb_addr)
            |=> (store[$past(wa_addr)] == $past(wa_data)));

    p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !r0_en |=> $stable(r0_data));

endmodule

// File: rtl/nibble_rate_buf.sv
module nibble_rate_buf #(
    parameter nrb_pkg::side_e SIDE = nrb_pkg::SIDE_TX,
    parameter int DEPTH = 36,
    parameter int DW    = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_addr_we,
    input  logic [AW-1:0] ctl_addr_wdata,
    input  logic          ctl_autoinc_wdata,
    input  logic          ctl_wr,
    input  logic [DW-1:0] ctl_wdata,
    input  logic          ctl_rd,
    output logic [DW-1:0] ctl_rdata,
    input  logic          vp_stb,
    input  logic [DW-1:0] vp_wdata,
    output logic [DW-1:0] vp_rdata,
    output logic [AW-1:0] vp_ptr,
    input  logic          mdm_tick,
    input  logic [DW-1:0] mdm_wdata,
    output logic [DW-1:0] mdm_rdata
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] cptr;
    logic [AW-1:0] vptr;
    logic [AW-1:0] mptr;
    logic          autoinc_q;

    logic          wb_en;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] wb_data;
    logic          r1_en;
    logic [AW-1:0] r1_addr;
    logic [DW-1:0] r1_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            autoinc_q <= 1'b0;
        end else if (ctl_addr_we) begin
            autoinc_q <= ctl_autoinc_wdata;
        end
    end

    nrb_ptr #(.DEPTH(DEPTH)) u_cptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctl_addr_we),
        .load_val (ctl_addr_wdata),
        .adv      (autoinc_q && (ctl_wr || ctl_rd)),
        .ptr      (cptr)
    );

    nrb_ptr #(.DEPTH(DEPTH)) u_vptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (1'b0),
        .load_val ('0),
        .adv      (vp_stb),
        .ptr      (vptr)
    );

    nrb_ptr #(.DEPTH(DEPTH)) u_mptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (1'b0),
        .load_val ('0),
        .adv      (mdm_tick),
        .ptr      (mptr)
    );

    // Side selection: which stream port writes and which reads.
    always_comb begin
        if (SIDE == nrb_pkg::SIDE_TX) begin
            wb_en   = vp_stb;
            wb_addr = vptr;
            wb_data = vp_wdata;
            r1_en   = mdm_tick;
            r1_addr = mptr;
        end else begin
            wb_en   = mdm_tick;
            wb_addr = mptr;
            wb_data = mdm_wdata;
            r1_en   = vp_stb;
            r1_addr = vptr;
        end
        vp_rdata  = (SIDE == nrb_pkg::SIDE_RX) ? r1_data : '0;
        mdm_rdata = (SIDE == nrb_pkg::SIDE_TX) ? r1_data : '0;
        vp_ptr    = vptr;
    end

    nrb_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wa_en   (ctl_wr),
        .wa_addr (cptr),
        .wa_data (ctl_wdata),
        .wb_en   (wb_en),
        .wb_addr (wb_addr),
        .wb_data (wb_data),
        .r0_en   (ctl_rd),
        .r0_addr (cptr),
        .r0_data (ctl_rdata),
        .r1_en   (r1_en),
        .r1_addr (r1_addr),
        .r1_data (r1_data)
    );

    p_vp_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vp_stb |=> (vp_ptr == (($past(vp_ptr) == LAST) ? '0 : $past(vp_ptr) + 1'b1)));

    p_side_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (SIDE == nrb_pkg::SIDE_TX) ? (vp_rdata == '0) : (mdm_rdata == '0));

endmodule

// File: tb/sim_nibble_rate_buf.sv
module sim_nibble_rate_buf;
    localparam int D = 36;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic       ctl_addr_we;
    logic [5:0] ctl_addr_wdata;
    logic       ctl_autoinc_wdata;
    logic       ctl_wr;
    logic [3:0] ctl_wdata;
    logic       ctl_rd;
    logic       vp_stb;
    logic [3:0] vp_wdata;
    logic       mdm_tick;
    logic [3:0] mdm_wdata;

    logic [3:0] t_ctl, t_vp, t_mdm, r_ctl, r_vp, r_mdm;
    logic [5:0] t_ptr, r_ptr;

    nibble_rate_buf #(.SIDE(nrb_pkg::SIDE_TX)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_addr_we(ctl_addr_we),
        .ctl_addr_wdata(ctl_addr_wdata), .ctl_autoinc_wdata(ctl_autoinc_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rd(ctl_rd), .ctl_rdata(t_ctl),
        .vp_stb(vp_stb), .vp_wdata(vp_wdata), .vp_rdata(t_vp), .vp_ptr(t_ptr),
        .mdm_tick(mdm_tick), .mdm_wdata(mdm_wdata), .mdm_rdata(t_mdm));

    nibble_rate_buf #(.SIDE(nrb_pkg::SIDE_RX)) u1 (
        .clk(clk), .rst_n(rst_n), .ctl_addr_we(ctl_addr_we),
        .ctl_addr_wdata(ctl_addr_wdata), .ctl_autoinc_wdata(ctl_autoinc_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rd(ctl_rd), .ctl_rdata(r_ctl),
        .vp_stb(vp_stb), .vp_wdata(vp_wdata), .vp_rdata(r_vp), .vp_ptr(r_ptr),
        .mdm_tick(mdm_tick), .mdm_wdata(mdm_wdata), .mdm_rdata(r_mdm));

    int checks = 0;
    int errors = 0;

    // Reference model, index 0 = transmit side, 1 = receive side.
    int mm [2][D];
    int ca [2];
    int ai [2];
    int vpp[2];
    int mp [2];
    int ectl[2];
    int estr[2];

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_step();
        for (int s = 0; s < 2; s++) begin
            if (!rst_n) begin
                for (int i = 0; i < D; i++) mm[s][i] = 0;
                ca[s] = 0; ai[s] = 0; vpp[s] = 0; mp[s] = 0;
                ectl[s] = 0; estr[s] = 0;
            end else begin
                // reads see content before this cycle's writes (R10)
                if (ctl_rd) ectl[s] = mm[s][ca[s]];
                if (s == 0 && mdm_tick) estr[s] = mm[s][mp[s]];
                if (s == 1 && vp_stb)   estr[s] = mm[s][vpp[s]];
                // stream write first, controller last so it wins (R8)
                if (s == 0 && vp_stb)   mm[s][vpp[s]] = int'(vp_wdata);
                if (s == 1 && mdm_tick) mm[s][mp[s]] = int'(mdm_wdata);
                if (ctl_wr) mm[s][ca[s]] = int'(ctl_wdata);
                if (ctl_addr_we) begin
                    ca[s] = int'(ctl_addr_wdata);
                    if (ca[s] >= D) ca[s] = ca[s] - D;
                    ai[s] = int'(ctl_autoinc_wdata);
                end else if (ai[s] != 0 && (ctl_wr || ctl_rd)) begin
                    ca[s] = (ca[s] + 1) % D;
                end
                if (vp_stb)   vpp[s] = (vpp[s] + 1) % D;
                if (mdm_tick) mp[s]  = (mp[s] + 1) % D;
            end
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        model_step();
        #2;
        chk(int'(t_ctl), ectl[0], {tag, " tx ctl_rdata"});
        chk(int'(r_ctl), ectl[1], {tag, " rx ctl_rdata"});
        chk(int'(t_mdm), estr[0], {tag, " tx mdm_rdata"});
        chk(int'(r_vp),  estr[1], {tag, " rx vp_rdata"});
        chk(int'(t_vp),  0, "R12 tx vp_rdata quiet");
        chk(int'(r_mdm), 0, "R12 rx mdm_rdata quiet");
        chk(int'(t_ptr), vpp[0], "R6 tx vp_ptr");
        chk(int'(r_ptr), vpp[1], "R6 rx vp_ptr");
    endtask

    task automatic idle();
        ctl_addr_we = 1'b0; ctl_wr = 1'b0; ctl_rd = 1'b0;
        vp_stb = 1'b0; mdm_tick = 1'b0;
    endtask

    task automatic ctl_load(input int a, input bit inc, input string tag);
        ctl_addr_we = 1'b1; ctl_addr_wdata = 6'(a); ctl_autoinc_wdata = inc;
        cyc(tag);
        idle();
    endtask

    task automatic ctl_write(input int d, input string tag);
        ctl_wr = 1'b1; ctl_wdata = 4'(d);
        cyc(tag);
        idle();
    endtask

    task automatic ctl_read(input string tag);
        ctl_rd = 1'b1;
        cyc(tag);
        idle();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle();
        cyc("R9");
        cyc("R9");
        rst_n = 1'b1;
        cyc("R9");
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        ctl_addr_wdata = '0; ctl_autoinc_wdata = 1'b0; ctl_wdata = '0;
        vp_wdata = '0; mdm_wdata = '0;
        idle();
        #2;
        do_reset();

        // R9: contents cleared by reset
        ctl_load(0, 1'b1, "R9");
        for (int i = 0; i < D; i++) ctl_read("R9");

        // R1: fill every entry, read back
        ctl_load(0, 1'b1, "R1");
        for (int i = 0; i < D; i++) ctl_write((i * 7 + 3) % 16, "R1");
        ctl_load(0, 1'b1, "R1");
        for (int i = 0; i < D; i++) ctl_read("R1");

        // R4: folded load and wrap from 35
        ctl_load(40, 1'b1, "R4");
        ctl_read("R4");
        ctl_load(35, 1'b1, "R4");
        ctl_read("R4");
        ctl_read("R4");

        // R3: auto-increment off keeps the address
        ctl_load(5, 1'b0, "R3");
        ctl_read("R3");
        ctl_read("R3");
        ctl_write(9, "R3");
        ctl_read("R3");

        // R5 / R7: streams through the wrap point
        for (int i = 0; i < 40; i++) begin
            vp_stb = 1'b1; vp_wdata = 4'(i % 16);
            mdm_tick = 1'b1; mdm_wdata = 4'(15 - (i % 16));
            cyc("R5");
        end
        idle();
        for (int i = 0; i < 40; i++) begin
            mdm_tick = 1'b1; mdm_wdata = 4'(i % 11);
            cyc("R7");
        end
        idle();
        for (int i = 0; i < 40; i++) begin
            vp_stb = 1'b1; vp_wdata = 4'(i % 13);
            cyc("R5");
        end
        idle();

        // R12: unused write data left no trace
        ctl_load(0, 1'b1, "R12");
        for (int i = 0; i < D; i++) ctl_read("R12");

        // R8: all pointers at 0, simultaneous writes to entry 0
        do_reset();
        ctl_wr = 1'b1; ctl_wdata = 4'd5;
        vp_stb = 1'b1; vp_wdata = 4'd10;
        mdm_tick = 1'b1; mdm_wdata = 4'd12;
        cyc("R8");
        idle();
        ctl_load(0, 1'b1, "R8");
        ctl_read("R8");

        // R10: controller read of entry 1 while stream writes it
        ctl_load(1, 1'b0, "R10");
        ctl_rd = 1'b1;
        vp_stb = 1'b1; vp_wdata = 4'd7;
        mdm_tick = 1'b1; mdm_wdata = 4'd3;
        cyc("R10");
        idle();
        ctl_read("R10");

        // R11: load together with a read
        ctl_load(10, 1'b1, "R11");
        ctl_rd = 1'b1; ctl_addr_we = 1'b1; ctl_addr_wdata = 6'd20; ctl_autoinc_wdata = 1'b1;
        cyc("R11");
        idle();
        ctl_write(4, "R11");
        ctl_load(20, 1'b0, "R11");
        ctl_read("R11");

        // R2: random mixed traffic
        for (int i = 0; i < 600; i++) begin
            ctl_addr_we       = ($urandom % 8) == 0;
            ctl_addr_wdata    = 6'($urandom);
            ctl_autoinc_wdata = 1'($urandom);
            ctl_wr            = ($urandom % 3) == 0;
            ctl_wdata         = 4'($urandom);
            ctl_rd            = ($urandom % 3) == 0;
            vp_stb            = 1'($urandom);
            vp_wdata          = 4'($urandom);
            mdm_tick          = 1'($urandom);
            mdm_wdata         = 4'($urandom);
            cyc("R2");
        end
        idle();
        cyc("R2");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule